// File: doc/BRIEF.md
# Start/Run Interlock Controller

This block turns discrete operator and plant inputs into one equipment run command. The run command can be set only from a start request. After that a seal-in path holds it until a run condition fails. It handles restart behaviour and non-safety sequencing only. The hardware stop chain remains the safety function, and pushbuttons reach the block already debounced.

The block treats its conditions in three ways:

- **Permissive inputs** are looked at only when a start is requested.
- **Interlock inputs** are checked on every clock edge.
- **The stop-circuit-healthy input** reads 1 when the circuit is intact. A pressed stop, lost power or a broken wire all read 0. Any 0 drops the run command and arms a reset-required latch. Restarting then takes two separate operator actions, made with the stop circuit healthy: first a reset press, then a new start press.

All state is registered on `clk_i`. The run command and the reset-required indicator change at the clock edge that samples the condition. The fault output follows its inputs within the same cycle. Input `rst_i` is a synchronous active-high reset.

Top module: `run_interlock_ctrl`

## Requirements
- R1: At a clock edge with `rst_i` high, `run_o` becomes 0 and `reset_req_o` becomes 1.
- R2: `run_o` goes from 0 to 1 at an edge only if, at that edge, all of the following hold:
  - `start_pb_i` is 1 and `auto_mode_i` is 1;
  - every bit of `perm_i` and every bit of `ilk_i` is 1;
  - `stop_ok_i` is 1;
  - `reset_req_o` is 0 and `trip_i` is 0.
- R3: While running, `run_o` stays 1 with `start_pb_i` and `auto_mode_i` at 0, as long as every interlock bit is 1, `stop_ok_i` is 1 and `trip_i` is 0.
- R4: At any edge where any bit of `ilk_i` is sampled 0, `run_o` becomes 0.
- R5: At any edge where `stop_ok_i` is sampled 0, `reset_req_o` becomes 1 and `run_o` becomes 0.
- R6: `reset_req_o` clears only at an edge where `reset_pb_i` is 1 and `stop_ok_i` is 1. A reset press with `stop_ok_i` at 0 leaves it set.
- R7: After `stop_ok_i` returns to 1, `run_o` stays 0 through the reset press. It rises only on a later start request.
- R8: Clearing a `perm_i` bit while running has no effect on `run_o`.
- R9: A stop loss and a start request on the same edge leave `run_o` at 0 and set `reset_req_o`.
- R10: A reset press and a start request on the same edge clear `reset_req_o` but leave `run_o` at 0.
- R11: `fault_o` equals `reset_req_o` OR `trip_i` in every cycle.
- R12: `trip_i` at 1 blocks a start and drops a running command at the edge where it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_pb_i | input | 1 | Start request, debounced |
| reset_pb_i | input | 1 | Operator reset request, debounced |
| auto_mode_i | input | 1 | Auto mode selected |
| perm_i | input | N_PERM | Start permissives, 1 = satisfied |
| ilk_i | input | N_ILK | Run interlocks, 1 = healthy |
| stop_ok_i | input | 1 | Stop circuit healthy, 0 = stopped or broken |
| trip_i | input | 1 | Trip active flag |
| run_o | output | 1 | Equipment run command |
| reset_req_o | output | 1 | Reset required indicator |
| fault_o | output | 1 | Fault indication |

## Verification
The assertions check a set of single-edge rules on every cycle:

- a rising run command is backed by a complete start request;
- an interlock or stop loss clears the run command at the next edge;
- a stop loss always arms the reset latch;
- the reset latch only clears under a healthy reset press;
- the run command never rises while a reset is pending.

Some behaviours only the bench's scenarios can show. The main one is the full restart ordering, where the run command stays off through stop restoration and reset and returns only on a fresh start. The others are the seal-in holding over many idle cycles, the immunity to permissive loss, and the two same-cycle collisions.

// File: rtl/runlk_pkg.sv
package runlk_pkg;
  typedef struct packed {
    logic perm_all;
    logic ilk_all;
  } cond_t;

  typedef enum logic [1:0] {
    RUN_IDLE   = 2'b00,
    RUN_ACTIVE = 2'b01
  } run_state_e;
endpackage

// File: rtl/runlk_cond_reduce.sv
module runlk_cond_reduce #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             all_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_chain
      if (g == 0) begin : g_first
        assign chain[g] = bits_i[g];
      end else begin : g_next
        assign chain[g] = chain[g-1] & bits_i[g];
      end
    end
  endgenerate

  assign all_o = chain[LAST];
endmodule

// File: rtl/runlk_restart_latch.sv
module runlk_restart_latch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic stop_ok_i,
  input  logic reset_pb_i,
  output logic pending_o
);
  logic pending_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                        pending_q <= 1'b1;
    else if (!stop_ok_i)              pending_q <= 1'b1;
    else if (reset_pb_i)              pending_q <= 1'b0;
  end

  assign pending_o = pending_q;

  // R5: a stop loss arms the latch at the next edge
  p_arm_on_loss_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !stop_ok_i |=> pending_q);

  // R6: clearing needs a healthy reset press
  p_clear_healthy_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(pending_q) |-> $past(reset_pb_i && stop_ok_i));
endmodule

// File: rtl/runlk_run_seal.sv
module runlk_run_seal
  import runlk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  start_pb_i,
  input  logic  auto_mode_i,
  input  cond_t cond_i,
  input  logic  stop_ok_i,
  input  logic  trip_i,
  input  logic  pending_i,
  output logic  run_o
);
  run_state_e state_q, state_d;
  logic hold_ok, start_ok;

  assign hold_ok  = cond_i.ilk_all & stop_ok_i & ~trip_i & ~pending_i;
  assign start_ok = start_pb_i & auto_mode_i & cond_i.perm_all & hold_ok;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RUN_IDLE:   if (start_ok) state_d = RUN_ACTIVE;
      RUN_ACTIVE: if (!hold_ok) state_d = RUN_IDLE;
      default:    state_d = RUN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= RUN_IDLE;
    else       state_q <= state_d;
  end

  assign run_o = (state_q == RUN_ACTIVE);

  // R4: an interlock loss clears the run command at the next edge
  p_ilk_drop_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !cond_i.ilk_all |=> !run_o);

  // R5: stop loss clears the run command
  p_stop_drop_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !stop_ok_i |=> !run_o);

  // R12: a trip clears the run command
  p_trip_drop_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    trip_i |=> !run_o);

  // R2: a rising command is backed by a full start request
  p_start_gate_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(run_o) |-> $past(start_pb_i && auto_mode_i && cond_i.perm_all));
endmodule

// File: rtl/run_interlock_ctrl.sv
module run_interlock_ctrl
  import runlk_pkg::*;
#(
  parameter int unsigned N_PERM = 4,
  parameter int unsigned N_ILK  = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_pb_i,
  input  logic              reset_pb_i,
  input  logic              auto_mode_i,
  input  logic [N_PERM-1:0] perm_i,
  input  logic [N_ILK-1:0]  ilk_i,
  input  logic              stop_ok_i,
  input  logic              trip_i,
  output logic              run_o,
  output logic              reset_req_o,
  output logic              fault_o
);
  cond_t cond;
  logic  pending;

  runlk_cond_reduce #(.WIDTH(N_PERM)) u_perm (
    .bits_i(perm_i),
    .all_o (cond.perm_all)
  );

  runlk_cond_reduce #(.WIDTH(N_ILK)) u_ilk (
    .bits_i(ilk_i),
    .all_o (cond.ilk_all)
  );

  runlk_restart_latch u_latch (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .stop_ok_i (stop_ok_i),
    .reset_pb_i(reset_pb_i),
    .pending_o (pending)
  );

  runlk_run_seal u_seal (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_pb_i (start_pb_i),
    .auto_mode_i(auto_mode_i),
    .cond_i     (cond),
    .stop_ok_i  (stop_ok_i),
    .trip_i     (trip_i),
    .pending_i  (pending),
    .run_o      (run_o)
  );

  assign reset_req_o = pending;
  assign fault_o     = pending | trip_i;

  // R7/R10: the run command never rises out of a pending reset
  p_no_auto_restart_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(run_o) |-> $past(!reset_req_o));

  // R1: reset leaves the block stopped with reset pending
  p_reset_state_r1: assert property (@(posedge clk_i)
    rst_i |=> (!run_o && reset_req_o));
endmodule

// File: tb/run_interlock_ctrl_tb_top.sv
`timescale 1ns/1ps
module run_interlock_ctrl_tb_top;
  localparam int NP = 4;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst, start_pb, reset_pb, auto_mode, stop_ok, trip;
  logic [NP-1:0] perm;
  logic [NI-1:0] ilk;
  logic run, rreq, fault;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  string cur_req = "R1";

  bit m_run, m_rr;

  always #2 clk = ~clk;

  run_interlock_ctrl #(.N_PERM(NP), .N_ILK(NI)) dut_i (
    .clk_i(clk), .rst_i(rst), .start_pb_i(start_pb), .reset_pb_i(reset_pb),
    .auto_mode_i(auto_mode), .perm_i(perm), .ilk_i(ilk), .stop_ok_i(stop_ok),
    .trip_i(trip), .run_o(run), .reset_req_o(rreq), .fault_o(fault)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_run <= 1'b0;
      m_rr  <= 1'b1;
    end else begin
      bit healthy;
      healthy = (&ilk) && stop_ok && !trip && !m_rr;
      if (m_run) m_run <= healthy;
      else       m_run <= healthy && start_pb && auto_mode && (&perm);
      if (!stop_ok)      m_rr <= 1'b1;
      else if (reset_pb) m_rr <= 1'b0;
    end
  end

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      chk(cur_req, run, m_run);
      chk(cur_req, rreq, m_rr);
      chk("R11", fault, m_rr | trip);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start_pb = 1'b1; step(); start_pb = 1'b0;
  endtask

  task automatic pulse_reset();
    reset_pb = 1'b1; step(); reset_pb = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start_pb = 0; reset_pb = 0; auto_mode = 1; stop_ok = 1; trip = 0;
    perm = '1; ilk = '1;
    @(negedge clk);
    step(2);
    rst = 1'b0;
    #1;
    chk("R1", run, 1'b0);
    chk("R1", rreq, 1'b1);
    chk("R11", fault, 1'b1);

    cur_req = "R7";
    pulse_start();
    chk("R7", run, 1'b0);

    cur_req = "R10";
    start_pb = 1; reset_pb = 1; step();
    start_pb = 0; reset_pb = 0;
    chk("R10", rreq, 1'b0);
    chk("R10", run, 1'b0);

    cur_req = "R2";
    pulse_start();
    chk("R2", run, 1'b1);

    cur_req = "R3";
    auto_mode = 0; step(5);
    chk("R3", run, 1'b1);
    auto_mode = 1;

    cur_req = "R8";
    perm[1] = 0; step(3);
    chk("R8", run, 1'b1);
    perm = '1;

    cur_req = "R4";
    ilk[2] = 0; step();
    chk("R4", run, 1'b0);
    ilk = '1; step(3);
    chk("R4", run, 1'b0);

    cur_req = "R2";
    auto_mode = 0; pulse_start();
    chk("R2", run, 1'b0);
    auto_mode = 1;
    perm[3] = 0; pulse_start();
    chk("R2", run, 1'b0);
    perm = '1;
    pulse_start();
    chk("R2", run, 1'b1);

    cur_req = "R5";
    stop_ok = 0; step();
    chk("R5", run, 1'b0);
    chk("R5", rreq, 1'b1);

    cur_req = "R6";
    pulse_reset();
    chk("R6", rreq, 1'b1);

    cur_req = "R7";
    stop_ok = 1; step(4);
    chk("R7", run, 1'b0);
    pulse_reset();
    chk("R7", rreq, 1'b0);
    step(3);
    chk("R7", run, 1'b0);
    pulse_start();
    chk("R7", run, 1'b1);

    cur_req = "R9";
    start_pb = 1; stop_ok = 0; step();
    start_pb = 0; stop_ok = 1;
    chk("R9", run, 1'b0);
    chk("R9", rreq, 1'b1);
    pulse_reset();

    cur_req = "R12";
    trip = 1; #1;
    chk("R11", fault, 1'b1);
    pulse_start();
    chk("R12", run, 1'b0);
    trip = 0; pulse_start();
    chk("R12", run, 1'b1);
    trip = 1; step();
    chk("R12", run, 1'b0);
    trip = 0; step(2);
    chk("R12", run, 1'b0);

    cur_req = "R1";
    pulse_start();
    rst = 1; step();
    chk("R1", run, 1'b0);
    chk("R1", rreq, 1'b1);
    rst = 0; step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule